// File: doc/BRIEF.md
# Parallel-Load Serial-Out Shift Register

An eight-stage shift register that is filled in parallel and emptied one bit at a time. When the active-low load pin is low, every stage follows its parallel input and keeps doing so while the pin stays low. Clock activity is ignored during that time. When the load pin is high, each rising edge of the effective shift clock moves the contents one stage toward the last stage, and the serial input enters stage 0. The effective shift clock is the OR of two clock pins. Either pin can therefore act as the clock while the other acts as an inhibit. The last stage and its complement are the outputs.

The block runs on a fast system clock. All pins pass through a synchronizer of `SYNC_DEPTH` flops (default two). A small state machine follows the synchronized combined clock. It has two states: `CK_LOW` and `CK_HIGH`. The transition `CK_LOW -> CK_HIGH` is the rising edge, and it may produce a shift. The transition `CK_HIGH -> CK_LOW` is the falling edge, and it never produces a shift. The output process of the machine picks one of three stage operations each cycle: `OP_LOAD` (load pin low), `OP_SHIFT` (rising edge with the load pin high) or `OP_HOLD` (all other cases).

Top module: `par_load_shreg`

## Requirements
- R1: While `shift_ld_n` is 0, stage i follows `par_in[i]`, including changes made while the pin stays low, and rising edges on the clock pins have no effect.
- R2: While `shift_ld_n` is 1, exactly one shift happens on each 0-to-1 transition of the combined clock (`clk_a | clk_b`). The stages hold in every other cycle. A release of the load pin that is synchronized in the same cycle as a clock rise produces a shift.
- R3: Each clock pin shifts the register on its own when the other pin is low.
- R4: While one clock pin is held at 1, pulses on the other clock pin cause no shift.
- R5: A rise of one pin while the other pin is 0 gives exactly one shift. A rise of one pin while the other pin is 1 gives none.
- R6: On a shift, `ser_in` enters stage 0 and stage i moves to stage i+1. `q_last` is stage 7. After a load, `q_last` shows `par_in[7]`, and the next seven shifts present `par_in[6]` down to `par_in[0]`.
- R7: `q_last_n` is always the inverse of `q_last`.
- R8: A synchronous active-low reset clears all stages to 0 and records the combined clock as high. A clock pin that is already high when reset is released therefore causes no shift.
- R9: A pin change driven between two system clock edges shows at the outputs after the third following rising edge: two edges in the synchronizer and one in the stages.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| shift_ld_n | input | 1 | 0 = parallel load (level), 1 = shift mode |
| clk_a | input | 1 | Shift clock pin, ORed with clk_b |
| clk_b | input | 1 | Shift clock pin, ORed with clk_a (usable as inhibit) |
| ser_in | input | 1 | Serial data into stage 0 |
| par_in | input | STAGES | Parallel data, bit i to stage i |
| q_last | output | 1 | Last stage |
| q_last_n | output | 1 | Complement of last stage |

## Verification
Two functions can fall in the same cycle: the parallel load and the shift edge. The bench provokes this by changing `shift_ld_n` and a clock pin on the same system-clock half-period, in both directions. When the load falls together with a clock rise, the load must win. When the load is released together with a clock rise, the stages must shift once from the loaded contents. Both cases are judged against a behavioural reference model that is compared on every clock, and also against hand-computed output bits. The spurious shift, where the inhibit pin rises while the clock pin is low, is provoked and judged in the same way.

// File: rtl/shreg_pkg.sv
package shreg_pkg;

    typedef enum logic {
        CK_LOW  = 1'b0,
        CK_HIGH = 1'b1
    } ck_state_t;

    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_LOAD  = 2'd1,
        OP_SHIFT = 2'd2
    } stage_op_t;

endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
    parameter int              WIDTH   = 12,
    parameter int              DEPTH   = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [WIDTH-1:0] ff [DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                ff[i] <= RST_VAL;
            end
        end else begin
            ff[0] <= din;
            for (int i = 1; i < DEPTH; i++) begin
                ff[i] <= ff[i-1];
            end
        end
    end

    assign dout = ff[DEPTH-1];

endmodule

// File: rtl/clk_edge_fsm.sv
module clk_edge_fsm
    import shreg_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      comb_clk,
    input  logic      shift_mode,
    output stage_op_t op
);

    ck_state_t state_q;
    ck_state_t state_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CK_HIGH;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CK_LOW:  if (comb_clk)  state_d = CK_HIGH;
            CK_HIGH: if (!comb_clk) state_d = CK_LOW;
        endcase
    end

    // outputs
    always_comb begin
        op = OP_HOLD;
        if (!shift_mode) begin
            op = OP_LOAD;
        end else begin
            unique case (state_q)
                CK_LOW:  if (comb_clk) op = OP_SHIFT;
                CK_HIGH: op = OP_HOLD;
            endcase
        end
    end

endmodule

// File: rtl/stage_bank.sv
module stage_bank
    import shreg_pkg::*;
#(
    parameter int STAGES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  stage_op_t         op,
    input  logic              ser,
    input  logic [STAGES-1:0] par,
    output logic [STAGES-1:0] stg
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg <= '0;
        end else begin
            unique case (op)
                OP_LOAD:  stg <= par;
                OP_SHIFT: stg <= {stg[STAGES-2:0], ser};
                OP_HOLD:  stg <= stg;
                default:  stg <= stg;
            endcase
        end
    end

endmodule

// File: rtl/par_load_shreg.sv
module par_load_shreg
    import shreg_pkg::*;
#(
    parameter int STAGES     = 8,
    parameter int SYNC_DEPTH = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_ld_n,
    input  logic              clk_a,
    input  logic              clk_b,
    input  logic              ser_in,
    input  logic [STAGES-1:0] par_in,
    output logic              q_last,
    output logic              q_last_n
);

    localparam int PIN_W = STAGES + 4;
    localparam logic [PIN_W-1:0] PIN_RST = {3'b111, 1'b0, {STAGES{1'b0}}};

    logic [PIN_W-1:0]  pins_raw;
    logic [PIN_W-1:0]  pins_s;
    logic              ld_s;
    logic              ca_s;
    logic              cb_s;
    logic              comb_s;
    logic              ser_s;
    logic [STAGES-1:0] par_s;
    logic [STAGES-1:0] stg;
    stage_op_t         op;

    assign pins_raw = {shift_ld_n, clk_a, clk_b, ser_in, par_in};

    pin_sync #(
        .WIDTH   (PIN_W),
        .DEPTH   (SYNC_DEPTH),
        .RST_VAL (PIN_RST)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (pins_raw),
        .dout  (pins_s)
    );

    assign ld_s   = pins_s[PIN_W-1];
    assign ca_s   = pins_s[PIN_W-2];
    assign cb_s   = pins_s[PIN_W-3];
    assign ser_s  = pins_s[STAGES];
    assign par_s  = pins_s[STAGES-1:0];
    assign comb_s = ca_s | cb_s;

    clk_edge_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .comb_clk   (comb_s),
        .shift_mode (ld_s),
        .op         (op)
    );

    stage_bank #(
        .STAGES (STAGES)
    ) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .op    (op),
        .ser   (ser_s),
        .par   (par_s),
        .stg   (stg)
    );

    assign q_last   = stg[STAGES-1];
    assign q_last_n = ~stg[STAGES-1];

endmodule

// File: rtl/shreg_checker.sv
module shreg_checker #(
    parameter int N = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         ld_s,
    input logic         comb_s,
    input logic         ser_s,
    input logic [N-1:0] par_s,
    input logic [N-1:0] stg
);

    assert_load_follow_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_s |=> stg == $past(par_s));

    assert_hold_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_s && !comb_s) |=> $stable(stg));

    assert_hold_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_s && $past(comb_s)) |=> $stable(stg));

    assert_shift_dir_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_s && comb_s && !$past(comb_s)) |=> stg == {$past(stg[N-2:0]), $past(ser_s)});

    assert_reset_clear_R8: assert property (@(posedge clk)
        !rst_n |=> stg == '0);

endmodule

bind par_load_shreg shreg_checker #(.N(STAGES)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .ld_s   (ld_s),
    .comb_s (comb_s),
    .ser_s  (ser_s),
    .par_s  (par_s),
    .stg    (stg)
);

// File: tb/par_load_shreg_tb_top.sv
module par_load_shreg_tb_top;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       shift_ld_n = 1'b1;
    logic       clk_a = 1'b0;
    logic       clk_b = 1'b0;
    logic       ser_in = 1'b0;
    logic [7:0] par_in = 8'h00;
    logic       q_last;
    logic       q_last_n;

    int    n_checks = 0;
    int    n_errors = 0;
    string cur_req = "R8";

    always #(CLK_PERIOD/2) clk = ~clk;

    par_load_shreg dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .shift_ld_n (shift_ld_n),
        .clk_a      (clk_a),
        .clk_b      (clk_b),
        .ser_in     (ser_in),
        .par_in     (par_in),
        .q_last     (q_last),
        .q_last_n   (q_last_n)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual %0b expected %0b at %0t", req, act, exp, $time);
        end
    endtask

    // behavioural reference: pins seen two edges late, then acted on
    typedef struct {
        bit       ld;
        bit       a;
        bit       b;
        bit       s;
        bit [7:0] p;
    } smp_t;

    smp_t pipe[$];
    bit   m_st[8];
    bit   m_prev;

    function automatic smp_t rst_smp();
        smp_t r;
        r.ld = 1; r.a = 1; r.b = 1; r.s = 0; r.p = 8'h00;
        return r;
    endfunction

    always @(posedge clk) begin
        smp_t cur;
        smp_t d;
        cur.ld = shift_ld_n; cur.a = clk_a; cur.b = clk_b;
        cur.s = ser_in; cur.p = par_in;
        if (!rst_n) begin
            pipe.delete();
            pipe.push_back(rst_smp());
            pipe.push_back(rst_smp());
            foreach (m_st[i]) m_st[i] = 0;
            m_prev = 1;
        end else begin
            d = pipe.pop_front();
            pipe.push_back(cur);
            if (!d.ld) begin
                foreach (m_st[i]) m_st[i] = d.p[i];
            end else if ((d.a || d.b) && !m_prev) begin
                for (int i = 7; i > 0; i--) m_st[i] = m_st[i-1];
                m_st[0] = d.s;
            end
            m_prev = d.a || d.b;
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            chk({cur_req, " model"}, q_last, m_st[7]);
            chk("R7 model", q_last_n, !m_st[7]);
        end
    end

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic pulse(input bit use_b);
        if (use_b) clk_b = 1; else clk_a = 1;
        settle();
        if (use_b) clk_b = 0; else clk_a = 0;
        settle();
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

    initial begin
        // R8: reset with clk_a already high, serial 1
        clk_a = 1; ser_in = 1;
        repeat (3) @(negedge clk);
        chk("R8 reset q", q_last, 1'b0);
        chk("R7 reset qn", q_last_n, 1'b1);
        rst_n = 1;
        settle();
        clk_a = 0;
        settle();
        cur_req = "R8";
        for (int k = 0; k < 7; k++) pulse(0);
        chk("R8 no spurious shift at release", q_last, 1'b0);
        cur_req = "R6";
        pulse(0);
        chk("R6 serial fill eighth shift", q_last, 1'b1);

        // R1: level load, clocks ignored
        cur_req = "R1";
        ser_in = 0;
        par_in = 8'hA5; shift_ld_n = 0;
        settle();
        chk("R1 load A5 bit7", q_last, 1'b1);
        pulse(0); pulse(1);
        chk("R1 clocks ignored during load", q_last, 1'b1);
        par_in = 8'h3C;
        settle();
        chk("R1 follows change while low", q_last, 1'b0);

        // R9: latency of three edges
        cur_req = "R9";
        par_in = 8'hFF;
        @(negedge clk); chk("R9 after one edge", q_last, 1'b0);
        @(negedge clk); chk("R9 after two edges", q_last, 1'b0);
        @(negedge clk); chk("R9 after three edges", q_last, 1'b1);

        // R6: shift order of B2 = 1011_0010
        cur_req = "R6";
        par_in = 8'hB2;
        settle();
        shift_ld_n = 1;
        settle();
        chk("R6 q shows H after load", q_last, 1'b1);
        for (int k = 6; k >= 0; k--) begin
            pulse(0);
            chk("R6 shift order", q_last, 1'(8'hB2 >> k));
        end
        pulse(0);
        chk("R6 zero entered from serial", q_last, 1'b0);

        // R5: inhibit rise while clock low -> one shift
        cur_req = "R5";
        par_in = 8'h80; shift_ld_n = 0; settle(); shift_ld_n = 1; settle();
        clk_b = 1; settle();
        chk("R5 inhibit rise with clock low shifts", q_last, 1'b0);
        clk_b = 0; settle();

        // R5/R4: rise while other high -> none
        par_in = 8'hC0; clk_a = 1;
        shift_ld_n = 0; settle(); shift_ld_n = 1; settle();
        chk("R5 loaded with clk_a high", q_last, 1'b1);
        clk_b = 1; settle();
        chk("R5 rise while other high no shift", q_last, 1'b1);
        clk_b = 0; settle();
        cur_req = "R4";
        clk_a = 0; settle();
        chk("R4 falling edge no shift", q_last, 1'b1);
        clk_b = 1; settle();
        cur_req = "R4";
        clk_b = 0; settle();
        par_in = 8'h80; shift_ld_n = 0; settle(); shift_ld_n = 1; settle();
        clk_b = 1; settle();
        pulse(0); pulse(0);
        chk("R4 clk_b high blocks clk_a", q_last, 1'b0);
        clk_b = 0; settle();
        par_in = 8'h80; shift_ld_n = 0; settle(); shift_ld_n = 1; settle();
        clk_a = 1; settle();
        chk("R5 clk_a rise shifts", q_last, 1'b0);
        pulse(1); pulse(1);
        chk("R4 clk_a high blocks clk_b", q_last, 1'b0);
        clk_a = 0; settle();

        // R3: clk_b alone as clock
        cur_req = "R3";
        par_in = 8'h40; shift_ld_n = 0; settle(); shift_ld_n = 1; settle();
        chk("R3 loaded 40", q_last, 1'b0);
        pulse(1);
        chk("R3 clk_b alone shifts", q_last, 1'b1);

        // R2: load and clock rise in the same cycle
        cur_req = "R2";
        par_in = 8'h01;
        shift_ld_n = 0; clk_a = 1;
        settle();
        chk("R2 load wins over coincident rise", q_last, 1'b0);
        clk_a = 0; par_in = 8'h40; settle();
        shift_ld_n = 1; clk_a = 1;
        settle();
        chk("R2 release with rise shifts once", q_last, 1'b1);
        clk_a = 0; settle();
        chk("R2 no shift on fall", q_last, 1'b0 ^ 1'b1);
        pulse(0);
        chk("R2 next rise shifts", q_last, 1'b0);

        cur_req = "R7";
        settle();
        $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

endmodule